// File: doc/BRIEF.md
# Speculative Instruction Commit Tracker

This block sits on the coprocessor side of an instruction offload link. It keeps one small state machine for each possible instruction id, so with the default 4-bit id it tracks sixteen slots. When the core hands over an instruction, the tracker records whether the coprocessor accepted or refused it. The core later sends commit messages on a channel that has no back-pressure. Each message is valid for exactly one cycle. It either confirms an id together with everything older, or kills an id together with everything newer. Age is taken as the wrapped distance from the oldest live id. An oldest pointer follows that id from cycle to cycle.

An execution unit asks to publish a finished instruction by presenting its id and data. The tracker takes the request in one of three ways:

- If the id is committed, it loads the request into a single result register.
- If the id is still speculative, it stalls the request.
- If the id is killed or unknown, it takes the request and throws it away.

A loaded result stays on the output until the core takes it. That handshake frees the slot, and the id can then be issued again.

Per-slot states are `EN_FREE`, `EN_SPEC_ACC`, `EN_SPEC_REJ` and `EN_DONE_OK`. Their transitions are:

- issue: `EN_FREE` goes to `EN_SPEC_ACC` if the instruction was accepted, or to `EN_SPEC_REJ` if it was refused.
- covering confirm: `EN_SPEC_ACC` goes to `EN_DONE_OK`, and `EN_SPEC_REJ` goes to `EN_FREE`.
- covering kill: either speculative state goes to `EN_FREE`.
- result handshake: `EN_DONE_OK` goes to `EN_FREE`.

The result register has the states `RS_EMPTY` and `RS_HOLD`. A load moves `RS_EMPTY` to `RS_HOLD`. A handshake moves `RS_HOLD` back to `RS_EMPTY`. A handshake that comes with a new load keeps the register in `RS_HOLD`.

Top module: `spec_commit_tracker`

## Requirements
- R1: After reset no slot is live. `result_valid` is 0, and an execution request for any id gets `exec_ready`=1 and produces no result.
- R2: An accepted instruction that has not been confirmed stalls its execution request (`exec_ready`=0). A refused instruction never produces a result.
- R3: A message with `cmt_valid`=1 and `cmt_kill`=0 for id C confirms every live instruction whose age distance is at most C's. Their requests are then loaded and published with the same id and data. Newer instructions stay stalled.
- R4: A message with `cmt_kill`=1 for id K removes every speculative instruction whose age distance is at least K's. Their later execution requests are taken (`exec_ready`=1) and dropped with no result. Older instructions are kept.
- R5: Age is the distance (id − oldest live id) mod 2^ID_W. Ids that wrap past the maximum value are therefore newer than the ids issued before them.
- R6: An instruction that is already confirmed ignores later messages. This includes a kill that names it or an older id.
- R7: A message whose id is not live but lies within the span from oldest to newest still applies its batch effect. If the id lies outside that span, it is taken as older than all live instructions: a confirm has no effect, and a kill removes all speculative instructions.
- R8: A message counts in the same cycle it arrives. An execution request in that cycle is granted if the message confirms the instruction, and its result appears the next cycle. The request is dropped if the message kills the instruction.
- R9: `result_valid`, `result_id` and `result_data` hold steady until `result_ready`=1. While the register is full and not draining, further requests stall. Each confirmed instruction publishes exactly one result. After that handshake the id can be issued again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_done | input | 1 | Issue handshake completed this cycle |
| issue_id | input | ID_W | Id of the issued instruction |
| issue_accept | input | 1 | 1 = accepted by the coprocessor, 0 = refused |
| cmt_valid | input | 1 | Commit message valid (one-cycle pulse) |
| cmt_id | input | ID_W | Id named by the commit message |
| cmt_kill | input | 1 | 0 = confirm id and older, 1 = kill id and newer |
| exec_valid | input | 1 | Execution unit has a finished instruction |
| exec_id | input | ID_W | Id of the finished instruction |
| exec_data | input | DATA_W | Result data of the finished instruction |
| exec_ready | output | 1 | Request taken (either loaded or dropped) |
| result_valid | output | 1 | Result register holds a publishable result |
| result_ready | input | 1 | Core takes the result |
| result_id | output | ID_W | Id of the held result |
| result_data | output | DATA_W | Data of the held result |

## Verification
The case of interest is a commit message that arrives in the same cycle as an execution request for the id it covers. The bench produces this case by raising `cmt_valid` and `exec_valid` together. It does so once with a confirm and once with a kill. For the confirm, it expects `exec_ready`=1 in that same cycle and `result_valid` one edge later. For the kill, it expects `exec_ready`=1 and no result to reach the scoreboard. A design that decides using only the registered slot state would stall in both cases, and the bench would report that stall.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    // Per-slot lifecycle of one offloaded instruction id.
    typedef enum logic [1:0] {
        EN_FREE     = 2'd0,
        EN_SPEC_ACC = 2'd1,
        EN_SPEC_REJ = 2'd2,
        EN_DONE_OK  = 2'd3
    } ent_st_e;

    // Occupancy of the single outgoing result register.
    typedef enum logic {
        RS_EMPTY = 1'b0,
        RS_HOLD  = 1'b1
    } res_st_e;

endpackage

// File: rtl/ctr_entry.sv
module ctr_entry
    import ctr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    issue_hit,
    input  logic    issue_acc,
    input  logic    commit_hit,
    input  logic    kill_hit,
    input  logic    retire,
    output ent_st_e state_q,
    output logic    ok_now,
    output logic    spec_now,
    output logic    live_nxt
);

    ent_st_e st_iss;
    ent_st_e st_cm;
    ent_st_e st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EN_FREE;
        else        state_q <= st_nxt;
    end

    // The issue is applied first, then the commit message, then the result handshake.
    always_comb begin
        st_iss = state_q;
        if (issue_hit) st_iss = issue_acc ? EN_SPEC_ACC : EN_SPEC_REJ;

        st_cm = st_iss;
        unique case (st_iss)
            EN_SPEC_ACC: begin
                if (kill_hit)        st_cm = EN_FREE;
                else if (commit_hit) st_cm = EN_DONE_OK;
            end
            EN_SPEC_REJ: begin
                if (kill_hit || commit_hit) st_cm = EN_FREE;
            end
            EN_FREE:    st_cm = EN_FREE;
            EN_DONE_OK: st_cm = EN_DONE_OK;
        endcase

        st_nxt = st_cm;
        if (retire && (st_cm == EN_DONE_OK)) st_nxt = EN_FREE;
    end

    always_comb begin
        ok_now   = (st_cm == EN_DONE_OK);
        spec_now = (st_cm == EN_SPEC_ACC);
        live_nxt = (st_nxt != EN_FREE);
    end

    // R2: a new issue only ever lands in an empty slot
    p_issue_into_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_hit |-> (state_q == EN_FREE));

    // R2: a refused instruction never becomes publishable
    p_rej_never_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EN_SPEC_REJ) |=> (state_q != EN_DONE_OK));

    // R6: a confirmed slot stays confirmed until its result leaves
    p_confirmed_sticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == EN_DONE_OK) && !retire) |=> (state_q == EN_DONE_OK));

    // R9: the result handshake frees the slot
    p_retire_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> (state_q == EN_FREE));

endmodule

// File: rtl/ctr_age.sv
module ctr_age #(
    parameter int ID_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  any_live,
    input  logic                  issue_done,
    input  logic [ID_W-1:0]       issue_id,
    input  logic [ID_W-1:0]       cmt_id,
    input  logic [(1<<ID_W)-1:0]  live_nxt,
    output logic [ID_W-1:0]       oldest_q,
    output logic                  win_ok,
    output logic [(1<<ID_W)-1:0]  older_eq,
    output logic [(1<<ID_W)-1:0]  newer_eq
);

    localparam int NENT = 1 << ID_W;

    logic [ID_W-1:0] newest_q;
    logic [ID_W-1:0] oldest_d;
    logic [ID_W-1:0] newest_d;
    logic [ID_W-1:0] oldest_eff;
    logic [ID_W-1:0] newest_eff;
    logic [ID_W-1:0] span;
    logic [ID_W-1:0] dist_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oldest_q <= '0;
            newest_q <= '0;
        end else begin
            oldest_q <= oldest_d;
            newest_q <= newest_d;
        end
    end

    // When the tracker is empty, a same-cycle issue becomes the window base.
    always_comb begin
        oldest_eff = (!any_live && issue_done) ? issue_id : oldest_q;
        newest_eff = issue_done ? issue_id : newest_q;
        newest_d   = newest_eff;
        span       = newest_eff - oldest_eff;
        dist_c     = cmt_id - oldest_eff;
        win_ok     = (dist_c <= span);
    end

    for (genvar gi = 0; gi < NENT; gi++) begin : g_dist
        logic [ID_W-1:0] dist_i;
        always_comb begin
            dist_i       = ID_W'(gi) - oldest_eff;
            older_eq[gi] = (dist_i <= dist_c);
            newer_eq[gi] = (dist_i >= dist_c);
        end
    end

    // Circular scan from the current base: the first slot still live next cycle becomes the oldest.
    always_comb begin
        logic            found;
        logic [ID_W-1:0] idx;
        oldest_d = oldest_eff;
        found    = 1'b0;
        for (int k = 0; k < NENT; k++) begin
            idx = oldest_eff + ID_W'(k);
            if (!found && live_nxt[idx]) begin
                oldest_d = idx;
                found    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ctr_result.sv
module ctr_result
    import ctr_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ID_W-1:0]   load_id,
    input  logic [DATA_W-1:0] load_data,
    input  logic              result_ready,
    output logic              result_valid,
    output logic [ID_W-1:0]   result_id,
    output logic [DATA_W-1:0] result_data,
    output logic              retire,
    output logic              slot_open
);

    res_st_e state_q;
    res_st_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= RS_EMPTY;
            result_id   <= '0;
            result_data <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                result_id   <= load_id;
                result_data <= load_data;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_EMPTY: if (load) state_d = RS_HOLD;
            RS_HOLD:  if (result_ready) state_d = load ? RS_HOLD : RS_EMPTY;
        endcase
    end

    always_comb begin
        result_valid = (state_q == RS_HOLD);
        retire       = (state_q == RS_HOLD) && result_ready;
        slot_open    = (state_q == RS_EMPTY) || retire;
    end

    // R9: the top never loads over a result the core has not taken
    p_load_only_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> ((state_q == RS_EMPTY) || result_ready));

    // R9: a held result does not change until it is taken
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !result_ready) |=> (result_valid && $stable(result_id) && $stable(result_data)));

endmodule

// File: rtl/spec_commit_tracker.sv
module spec_commit_tracker
    import ctr_pkg::*;
#(
    parameter int ID_W   = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_done,
    input  logic [ID_W-1:0]   issue_id,
    input  logic              issue_accept,
    input  logic              cmt_valid,
    input  logic [ID_W-1:0]   cmt_id,
    input  logic              cmt_kill,
    input  logic              exec_valid,
    input  logic [ID_W-1:0]   exec_id,
    input  logic [DATA_W-1:0] exec_data,
    output logic              exec_ready,
    output logic              result_valid,
    input  logic              result_ready,
    output logic [ID_W-1:0]   result_id,
    output logic [DATA_W-1:0] result_data
);

    localparam int NENT = 1 << ID_W;

    ent_st_e         ent_state [NENT];
    logic [NENT-1:0] ent_ok;
    logic [NENT-1:0] ent_spec;
    logic [NENT-1:0] live_nxt;
    logic [NENT-1:0] live_q;
    logic [NENT-1:0] older_eq;
    logic [NENT-1:0] newer_eq;
    logic            any_live;
    logic            win_ok;
    logic [ID_W-1:0] oldest_q;
    logic            load;
    logic            retire;
    logic            slot_open;
    logic            dup;

    ctr_age #(.ID_W(ID_W)) u_age (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_live   (any_live),
        .issue_done (issue_done),
        .issue_id   (issue_id),
        .cmt_id     (cmt_id),
        .live_nxt   (live_nxt),
        .oldest_q   (oldest_q),
        .win_ok     (win_ok),
        .older_eq   (older_eq),
        .newer_eq   (newer_eq)
    );

    for (genvar gi = 0; gi < NENT; gi++) begin : g_slot
        logic issue_hit;
        logic commit_hit;
        logic kill_hit;
        logic retire_hit;

        always_comb begin
            issue_hit  = issue_done && (issue_id == ID_W'(gi));
            commit_hit = cmt_valid && !cmt_kill && win_ok && older_eq[gi];
            kill_hit   = cmt_valid && cmt_kill && (!win_ok || newer_eq[gi]);
            retire_hit = retire && (result_id == ID_W'(gi));
        end

        ctr_entry u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .issue_hit  (issue_hit),
            .issue_acc  (issue_accept),
            .commit_hit (commit_hit),
            .kill_hit   (kill_hit),
            .retire     (retire_hit),
            .state_q    (ent_state[gi]),
            .ok_now     (ent_ok[gi]),
            .spec_now   (ent_spec[gi]),
            .live_nxt   (live_nxt[gi])
        );

        assign live_q[gi] = (ent_state[gi] != EN_FREE);
    end

    assign any_live = |live_q;

    // Confirmed: load when the register can take it. Speculative: stall. Otherwise: take and drop.
    always_comb begin
        dup        = result_valid && (result_id == exec_id);
        exec_ready = 1'b0;
        load       = 1'b0;
        if (exec_valid) begin
            if (ent_ok[exec_id]) begin
                if (slot_open && !dup) begin
                    exec_ready = 1'b1;
                    load       = 1'b1;
                end
            end else if (!ent_spec[exec_id]) begin
                exec_ready = 1'b1;
            end
        end
    end

    ctr_result #(.ID_W(ID_W), .DATA_W(DATA_W)) u_result (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .load_id      (exec_id),
        .load_data    (exec_data),
        .result_ready (result_ready),
        .result_valid (result_valid),
        .result_id    (result_id),
        .result_data  (result_data),
        .retire       (retire),
        .slot_open    (slot_open)
    );

    // R3: a published result always belongs to a confirmed slot
    p_result_confirmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (ent_state[result_id] == EN_DONE_OK));

    // R5: the oldest pointer names a live slot whenever any slot is live
    p_oldest_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
        any_live |-> live_q[oldest_q]);

    // R1: nothing is live or published in the first cycle after reset
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!result_valid && !any_live));

endmodule

// File: tb/tb_spec_commit_tracker.sv
module tb_spec_commit_tracker;

    localparam int CLK_P  = 10;
    localparam int ID_W   = 4;
    localparam int DATA_W = 32;

    typedef struct {
        logic [ID_W-1:0]   id;
        logic [DATA_W-1:0] data;
        string             req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              issue_done = 1'b0;
    logic [ID_W-1:0]   issue_id = '0;
    logic              issue_accept = 1'b0;
    logic              cmt_valid = 1'b0;
    logic [ID_W-1:0]   cmt_id = '0;
    logic              cmt_kill = 1'b0;
    logic              exec_valid = 1'b0;
    logic [ID_W-1:0]   exec_id = '0;
    logic [DATA_W-1:0] exec_data = '0;
    logic              exec_ready;
    logic              result_valid;
    logic              result_ready = 1'b1;
    logic [ID_W-1:0]   result_id;
    logic [DATA_W-1:0] result_data;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    exp_t sb_q[$];

    always #(CLK_P/2) clk = ~clk;

    spec_commit_tracker #(.ID_W(ID_W), .DATA_W(DATA_W)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_done   (issue_done),
        .issue_id     (issue_id),
        .issue_accept (issue_accept),
        .cmt_valid    (cmt_valid),
        .cmt_id       (cmt_id),
        .cmt_kill     (cmt_kill),
        .exec_valid   (exec_valid),
        .exec_id      (exec_id),
        .exec_data    (exec_data),
        .exec_ready   (exec_ready),
        .result_valid (result_valid),
        .result_ready (result_ready),
        .result_id    (result_id),
        .result_data  (result_data)
    );

    function automatic logic [DATA_W-1:0] pattern(input logic [ID_W-1:0] id);
        return 32'hC0DE_0000 ^ {24'h0, id, id};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic issue(input logic [ID_W-1:0] id, input logic acc);
        issue_done = 1'b1; issue_id = id; issue_accept = acc;
        tick();
        issue_done = 1'b0;
    endtask

    task automatic commit(input logic [ID_W-1:0] id, input logic kill);
        cmt_valid = 1'b1; cmt_id = id; cmt_kill = kill;
        tick();
        cmt_valid = 1'b0; cmt_kill = 1'b0;
    endtask

    // The driver pushes the expected item when it expects a result.
    task automatic exec_try(input logic [ID_W-1:0] id, input logic exp_rdy, input logic exp_res, input string req);
        exp_t e;
        exec_valid = 1'b1; exec_id = id; exec_data = pattern(id);
        #1;
        check(req, "exec_ready", 32'(exec_ready), 32'(exp_rdy));
        if (exp_res) begin
            e.id = id; e.data = pattern(id); e.req = req;
            sb_q.push_back(e);
        end
        tick();
        exec_valid = 1'b0;
        tick();
    endtask

    // The monitor pops and compares at each result handshake.
    always @(negedge clk) begin
        if (rst_n && result_valid && result_ready) begin
            exp_t e;
            if (sb_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R4 unexpected result: got id %0h expected none", result_id);
            end else begin
                e = sb_q.pop_front();
                check(e.req, "result_id", 32'(result_id), 32'(e.id));
                check(e.req, "result_data", result_data, e.data);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        // R1
        check("R1", "result_valid after reset", 32'(result_valid), 0);
        exec_try(4'd7, 1'b1, 1'b0, "R1");

        // R2 / R3 / R4
        issue(4'd1, 1'b1); issue(4'd2, 1'b1); issue(4'd3, 1'b0); issue(4'd5, 1'b1);
        exec_try(4'd2, 1'b0, 1'b0, "R2");
        commit(4'd2, 1'b0);
        exec_try(4'd2, 1'b1, 1'b1, "R3");
        exec_try(4'd5, 1'b0, 1'b0, "R3");
        exec_try(4'd1, 1'b1, 1'b1, "R3");
        commit(4'd3, 1'b1);
        exec_try(4'd5, 1'b1, 1'b0, "R4");
        exec_try(4'd3, 1'b1, 1'b0, "R2");

        // R6 and one result per instruction (R9)
        issue(4'd6, 1'b1);
        commit(4'd6, 1'b0);
        commit(4'd6, 1'b1);
        exec_try(4'd6, 1'b1, 1'b1, "R6");
        exec_try(4'd6, 1'b1, 1'b0, "R9");

        // R5: wrapped ids
        issue(4'd14, 1'b1); issue(4'd15, 1'b1); issue(4'd0, 1'b1); issue(4'd1, 1'b1);
        commit(4'd0, 1'b1);
        exec_try(4'd15, 1'b0, 1'b0, "R5");
        commit(4'd15, 1'b0);
        exec_try(4'd14, 1'b1, 1'b1, "R5");
        exec_try(4'd15, 1'b1, 1'b1, "R5");
        exec_try(4'd1, 1'b1, 1'b0, "R5");

        // R7: unknown ids inside and outside the window
        issue(4'd2, 1'b1); issue(4'd4, 1'b1);
        commit(4'd3, 1'b0);
        exec_try(4'd4, 1'b0, 1'b0, "R7");
        commit(4'd3, 1'b1);
        exec_try(4'd4, 1'b1, 1'b0, "R7");
        exec_try(4'd2, 1'b1, 1'b1, "R7");
        issue(4'd8, 1'b1); issue(4'd9, 1'b1);
        commit(4'd7, 1'b0);
        exec_try(4'd8, 1'b0, 1'b0, "R7");
        commit(4'd7, 1'b1);
        exec_try(4'd8, 1'b1, 1'b0, "R7");
        exec_try(4'd9, 1'b1, 1'b0, "R7");

        // R8: a commit message and an execution request in the same cycle
        issue(4'd10, 1'b1);
        begin
            exp_t e;
            cmt_valid = 1'b1; cmt_id = 4'd10; cmt_kill = 1'b0;
            exec_valid = 1'b1; exec_id = 4'd10; exec_data = pattern(4'd10);
            #1;
            check("R8", "exec_ready with confirm", 32'(exec_ready), 1);
            e.id = 4'd10; e.data = pattern(4'd10); e.req = "R8";
            sb_q.push_back(e);
            tick();
            cmt_valid = 1'b0; exec_valid = 1'b0;
            check("R8", "result_valid next cycle", 32'(result_valid), 1);
            tick();
        end
        issue(4'd11, 1'b1);
        cmt_valid = 1'b1; cmt_id = 4'd11; cmt_kill = 1'b1;
        exec_valid = 1'b1; exec_id = 4'd11; exec_data = pattern(4'd11);
        #1;
        check("R8", "exec_ready with kill", 32'(exec_ready), 1);
        tick();
        cmt_valid = 1'b0; cmt_kill = 1'b0; exec_valid = 1'b0;
        tick();

        // R9: hold under back-pressure, ignored kill, then id reuse
        result_ready = 1'b0;
        issue(4'd12, 1'b1); issue(4'd13, 1'b1);
        commit(4'd13, 1'b0);
        exec_try(4'd12, 1'b1, 1'b1, "R9");
        exec_try(4'd13, 1'b0, 1'b0, "R9");
        commit(4'd12, 1'b1);
        check("R9", "held valid", 32'(result_valid), 1);
        check("R9", "held id", 32'(result_id), 32'd12);
        result_ready = 1'b1;
        tick();
        exec_try(4'd13, 1'b1, 1'b1, "R6");
        issue(4'd12, 1'b1);
        commit(4'd12, 1'b0);
        exec_try(4'd12, 1'b1, 1'b1, "R9");

        repeat (3) tick();
        check("R9", "pending results", 32'(sb_q.size()), 0);
        finish_run();
    end

endmodule